// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Front End

This block is the software-facing side of a CMOS-style real-time clock. Software reaches it through two byte-wide ports that share one bus: a write to the index port (`bus_port` = 0, the port at system address 0x70) latches a register number, and every later read or write on the data port (`bus_port` = 1, address 0x71) goes to the register at that number. The index stays latched, so a run of data accesses to one register needs only one index write.

The block holds the seven time-of-day and date bytes, two control registers, an event-flag register and a constant validity register. A divider counts 32.768 kHz tick enables and issues a one-cycle update strobe. The first strobe comes half a period after the divider is released, and later ones come every full period. On each strobe the time bytes take the next-time value that an external calendar counter supplies, and the update-ended flag is raised. The counter gets the format and daylight-saving selections from dedicated outputs. Calendar arithmetic is not done here.

The divider is a three-state machine. STOPPED holds the tick count at zero while register A does not carry the run code. STOPPED goes to FIRST once the run code is present. FIRST counts `HALF_TICKS` ticks, then goes to STEADY and issues an update. STEADY issues an update every `FULL_TICKS` ticks. From FIRST or STEADY the machine returns to STOPPED, with the count cleared, as soon as the run code is removed.

Top module: `rtc_indexed_front`

## Requirements
- R1: A write on the index port stores `bus_wdata[6:0]` as the selected index. The index does not change until the next index-port write, so repeated data reads and writes all reach the same register.
- R2: After reset the index is 0, register A reads 0x70, register B reads 0x00, register C reads 0x00, all time bytes read 0x00, and `update_stb`, `fmt_binary`, `fmt_24h` and `dst_enable` are 0.
- R3: The divider runs only while register A bits 6:4 equal 3'b010 (for example the value 0x20). Any other value, such as 0x70, holds the divider in reset, and no update strobe occurs.
- R4: The time bytes are at offsets 0x00 (seconds), 0x02 (minutes), 0x04 (hours), 0x07 (day), 0x08 (month), 0x09 (year) and 0x32 (century). `next_time` carries them as bytes 0 to 6 in that same order, with seconds in bits 7:0.
- R5: Suppose ticks arrive every cycle and register A receives the run code at clock edge k. Then `update_stb` is high only in the cycle after edge k+HALF_TICKS. At edge k+HALF_TICKS+1 the time bytes load `next_time` and register C bit 4 (update ended) sets.
- R6: After an update, the next update strobe comes FULL_TICKS ticks later, and the strobe lasts exactly one cycle.
- R7: While register B bit 7 (halt) is set, the divider keeps counting but a period end gives no strobe, no time load and no flag. Time bytes written by software keep their values.
- R8: A data read of register C (offset 0x0C) returns the flags and clears all of them. Bit 7 sets together with bit 4 when register B bit 4 (update interrupt enable) is 1. Bits 6 and 5 always read 0.
- R9: If the update flag is set in the same cycle as a register C read, that read returns the old flags and the new flag stays set for the next read.
- R10: Register D (offset 0x0D) always reads 0x80, and writes to it have no effect.
- R11: Register B reads back as written, and its bits 2, 1 and 0 drive `fmt_binary`, `fmt_24h` and `dst_enable`. Register A reads back bits 6:0 as written, with bit 7 reading 0.
- R12: The divider counts only in cycles where `tick_en` is high. Cycles without a tick delay the update by the same number of cycles.
- R13: Offsets that are not listed read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle enable at 32.768 kHz |
| bus_wr | input | 1 | Port write strobe |
| bus_rd | input | 1 | Port read strobe |
| bus_port | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Data-port read value for the selected register (combinational) |
| next_time | input | 56 | Next time bytes from the calendar counter, seconds in the low byte |
| update_stb | output | 1 | One-cycle update strobe; the time bytes load at the end of this cycle |
| fmt_binary | output | 1 | Binary data format selected |
| fmt_24h | output | 1 | 24-hour mode selected |
| dst_enable | output | 1 | Daylight saving enabled |

## Verification
The assertions check, on every cycle, the rules that hold at any time:
- the index stays put when there is no index write;
- a strobe appears only with the run code present and halt clear, and it lasts one cycle;
- a strobe loads `next_time` and sets the update flag, even in the cycle of a register C read;
- without a strobe or a data write, the time bytes do not move;
- register C clears after a read, and its unused bits stay zero;
- register D reads 0x80.

The exact placement of the half-period and full-period strobes, the delay caused by missing ticks, and the same-cycle read-versus-set ordering depend on edge counts since the release. Only the bench scenarios show these, by counting edges. The reset values, the effect of writes to unlisted offsets and the mapping of register B to the format outputs are also shown only by the scenarios.

// File: rtl/rtc_idx_pkg.sv
package rtc_idx_pkg;

    localparam int IDX_W    = 7;
    localparam int NUM_TIME = 7;

    // Register offsets seen through the data port
    localparam logic [IDX_W-1:0] OFS_SEC   = 7'h00;
    localparam logic [IDX_W-1:0] OFS_MIN   = 7'h02;
    localparam logic [IDX_W-1:0] OFS_HOUR  = 7'h04;
    localparam logic [IDX_W-1:0] OFS_DAY   = 7'h07;
    localparam logic [IDX_W-1:0] OFS_MON   = 7'h08;
    localparam logic [IDX_W-1:0] OFS_YEAR  = 7'h09;
    localparam logic [IDX_W-1:0] OFS_CENT  = 7'h32;
    localparam logic [IDX_W-1:0] OFS_CTLA  = 7'h0A;
    localparam logic [IDX_W-1:0] OFS_CTLB  = 7'h0B;
    localparam logic [IDX_W-1:0] OFS_STAT  = 7'h0C;
    localparam logic [IDX_W-1:0] OFS_VALID = 7'h0D;

    localparam logic [2:0] DIV_RUN_CODE = 3'b010;
    localparam logic [7:0] CTLA_RESET   = 8'h70;
    localparam logic [7:0] VALID_VALUE  = 8'h80;

    // Control B bit positions
    localparam int B_HALT = 7;
    localparam int B_UIE  = 4;
    localparam int B_BIN  = 2;
    localparam int B_24H  = 1;
    localparam int B_DST  = 0;

    // Status C bit positions
    localparam int C_ANY = 7;
    localparam int C_UPD = 4;

    typedef enum logic [1:0] {
        DIV_STOPPED = 2'd0,
        DIV_FIRST   = 2'd1,
        DIV_STEADY  = 2'd2
    } div_state_e;

    // Offset of time byte i; byte order matches next_time packing
    function automatic logic [IDX_W-1:0] time_offset(input int i);
        logic [IDX_W-1:0] ofs;
        case (i)
            0:       ofs = OFS_SEC;
            1:       ofs = OFS_MIN;
            2:       ofs = OFS_HOUR;
            3:       ofs = OFS_DAY;
            4:       ofs = OFS_MON;
            5:       ofs = OFS_YEAR;
            default: ofs = OFS_CENT;
        endcase
        return ofs;
    endfunction

endpackage

// File: rtl/rtc_divider_fsm.sv
module rtc_divider_fsm
    import rtc_idx_pkg::*;
#(
    parameter int HALF_TICKS = 16384,
    parameter int FULL_TICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic halt,
    input  logic tick_en,
    output logic update_stb
);

    localparam int CNT_W = $clog2(FULL_TICKS);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_TICKS - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_TICKS - 1);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             period_end;

    // Next-state and count logic
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        period_end = 1'b0;
        unique case (state_q)
            DIV_STOPPED: begin
                cnt_d = '0;
                if (run) state_d = DIV_FIRST;
            end
            DIV_FIRST: begin
                if (!run) begin
                    state_d = DIV_STOPPED;
                    cnt_d   = '0;
                end else if (tick_en) begin
                    if (cnt_q == HALF_LAST) begin
                        period_end = 1'b1;
                        cnt_d      = '0;
                        state_d    = DIV_STEADY;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            DIV_STEADY: begin
                if (!run) begin
                    state_d = DIV_STOPPED;
                    cnt_d   = '0;
                end else if (tick_en) begin
                    if (cnt_q == FULL_LAST) begin
                        period_end = 1'b1;
                        cnt_d      = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = DIV_STOPPED;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_STOPPED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        update_stb = period_end && !halt;
    end

endmodule

// File: rtl/rtc_time_bank.sv
module rtc_time_bank
    import rtc_idx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  data_wr,
    input  logic [IDX_W-1:0]      index,
    input  logic [7:0]            wdata,
    input  logic                  load,
    input  logic [NUM_TIME*8-1:0] next_time,
    output logic [NUM_TIME*8-1:0] time_flat,
    output logic                  hit,
    output logic [7:0]            rd_byte
);

    logic [NUM_TIME-1:0] sel_vec;

    for (genvar i = 0; i < NUM_TIME; i++) begin : g_field
        localparam logic [IDX_W-1:0] FOFS = time_offset(i);
        logic [7:0] field_q;

        assign sel_vec[i] = (index == FOFS);

        // A software write in the same cycle as a load takes priority
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field_q <= 8'h00;
            end else if (data_wr && sel_vec[i]) begin
                field_q <= wdata;
            end else if (load) begin
                field_q <= next_time[i*8 +: 8];
            end
        end

        assign time_flat[i*8 +: 8] = field_q;
    end

    assign hit = |sel_vec;

    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < NUM_TIME; i++) begin
            if (sel_vec[i]) rd_byte = rd_byte | time_flat[i*8 +: 8];
        end
    end

endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
    import rtc_idx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_clear,
    input  logic       upd_event,
    input  logic       irq_enable,
    output logic [7:0] flags_q
);

    logic [7:0] base, flags_d;

    // A set arriving with a read survives the clear
    always_comb begin
        base    = rd_clear ? 8'h00 : flags_q;
        flags_d = base;
        if (upd_event) begin
            flags_d[C_UPD] = 1'b1;
            if (irq_enable) flags_d[C_ANY] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= 8'h00;
        else        flags_q <= flags_d;
    end

endmodule

// File: rtl/rtc_indexed_front.sv
module rtc_indexed_front
    import rtc_idx_pkg::*;
#(
    parameter int HALF_TICKS = 16384,
    parameter int FULL_TICKS = 32768
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic                  bus_port,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    input  logic [NUM_TIME*8-1:0] next_time,
    output logic                  update_stb,
    output logic                  fmt_binary,
    output logic                  fmt_24h,
    output logic                  dst_enable
);

    logic [IDX_W-1:0]      index_q;
    logic [7:0]            ctrl_a_q, ctrl_b_q, status_q;
    logic [NUM_TIME*8-1:0] time_flat;
    logic                  idx_wr, data_wr, rd_stat, div_run, time_hit;
    logic [7:0]            time_rd;

    assign idx_wr  = bus_wr && !bus_port;
    assign data_wr = bus_wr && bus_port;
    assign rd_stat = bus_rd && bus_port && (index_q == OFS_STAT);

    // Index latch and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q  <= '0;
            ctrl_a_q <= CTLA_RESET;
            ctrl_b_q <= 8'h00;
        end else begin
            if (idx_wr) index_q <= bus_wdata[IDX_W-1:0];
            if (data_wr && index_q == OFS_CTLA) ctrl_a_q <= {1'b0, bus_wdata[6:0]};
            if (data_wr && index_q == OFS_CTLB) ctrl_b_q <= bus_wdata;
        end
    end

    assign div_run    = (ctrl_a_q[6:4] == DIV_RUN_CODE);
    assign fmt_binary = ctrl_b_q[B_BIN];
    assign fmt_24h    = ctrl_b_q[B_24H];
    assign dst_enable = ctrl_b_q[B_DST];

    rtc_divider_fsm #(
        .HALF_TICKS(HALF_TICKS),
        .FULL_TICKS(FULL_TICKS)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (div_run),
        .halt      (ctrl_b_q[B_HALT]),
        .tick_en   (tick_en),
        .update_stb(update_stb)
    );

    rtc_time_bank u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (data_wr),
        .index    (index_q),
        .wdata    (bus_wdata),
        .load     (update_stb),
        .next_time(next_time),
        .time_flat(time_flat),
        .hit      (time_hit),
        .rd_byte  (time_rd)
    );

    rtc_status_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_clear  (rd_stat),
        .upd_event (update_stb),
        .irq_enable(ctrl_b_q[B_UIE]),
        .flags_q   (status_q)
    );

    // Data-port read selection
    always_comb begin
        if (time_hit) begin
            bus_rdata = time_rd;
        end else begin
            case (index_q)
                OFS_CTLA:  bus_rdata = ctrl_a_q;
                OFS_CTLB:  bus_rdata = ctrl_b_q;
                OFS_STAT:  bus_rdata = status_q;
                OFS_VALID: bus_rdata = VALID_VALUE;
                default:   bus_rdata = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/rtc_indexed_front_chk.sv
module rtc_indexed_front_chk
    import rtc_idx_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic                  bus_port,
    input logic [7:0]            bus_rdata,
    input logic [NUM_TIME*8-1:0] next_time,
    input logic                  update_stb,
    input logic [IDX_W-1:0]      index_q,
    input logic [7:0]            ctrl_a_q,
    input logic [7:0]            ctrl_b_q,
    input logic [7:0]            status_q,
    input logic [NUM_TIME*8-1:0] time_flat
);

    assert_index_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && !bus_port) |=> $stable(index_q))
        else $error("index changed without index write");

    assert_stb_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |-> (ctrl_a_q[6:4] == DIV_RUN_CODE))
        else $error("strobe while divider held");

    assert_time_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (update_stb && !(bus_wr && bus_port)) |=> (time_flat == $past(next_time)))
        else $error("time bytes did not load next_time");

    // Also covers R9: flag set even when a status read clears in the same cycle
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |=> status_q[C_UPD])
        else $error("update flag not set");

    assert_stb_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |=> !update_stb)
        else $error("strobe longer than one cycle");

    assert_halt_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        update_stb |-> !ctrl_b_q[B_HALT])
        else $error("strobe while halted");

    assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_stb && !(bus_wr && bus_port)) |=> $stable(time_flat))
        else $error("time bytes moved without cause");

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_port && index_q == OFS_STAT && !update_stb) |=> (status_q == 8'h00))
        else $error("status read did not clear");

    assert_unused_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[6:5] == 2'b00)
        else $error("unused status bits set");

    assert_valid_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_port && index_q == OFS_VALID) |-> (bus_rdata == 8'h80))
        else $error("register D value wrong");

endmodule

bind rtc_indexed_front rtc_indexed_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_port  (bus_port),
    .bus_rdata (bus_rdata),
    .next_time (next_time),
    .update_stb(update_stb),
    .index_q   (index_q),
    .ctrl_a_q  (ctrl_a_q),
    .ctrl_b_q  (ctrl_b_q),
    .status_q  (status_q),
    .time_flat (time_flat)
);

// File: tb/rtc_indexed_front_test.sv
module rtc_indexed_front_test;

    localparam int HALF = 16384;
    localparam int FULL = 32768;
    localparam int GAP  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_port = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [55:0] next_time = '0;
    logic        update_stb, fmt_binary, fmt_24h, dst_enable;

    int unsigned cyc = 0;
    int unsigned stb_count = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    rtc_indexed_front #(.HALF_TICKS(HALF), .FULL_TICKS(FULL)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_port(bus_port),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .next_time(next_time), .update_stb(update_stb),
        .fmt_binary(fmt_binary), .fmt_24h(fmt_24h), .dst_enable(dst_enable)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && update_stb) stb_count <= stb_count + 1;

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic port, input logic [7:0] d);
        @(negedge clk);
        bus_port = port; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(output logic [7:0] d);
        @(negedge clk);
        bus_port = 1'b1; bus_rd = 1'b1;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic reg_write(input logic [6:0] ofs, input logic [7:0] d);
        bus_write(1'b0, {1'b0, ofs});
        bus_write(1'b1, d);
    endtask

    task automatic reg_read(input logic [6:0] ofs, output logic [7:0] d);
        bus_write(1'b0, {1'b0, ofs});
        bus_read(d);
    endtask

    task automatic wait_edge(input int unsigned n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R2", "update_stb", {7'd0, update_stb}, 8'h00);
        chk("R2", "format outputs", {5'd0, fmt_binary, fmt_24h, dst_enable}, 8'h00);
        bus_read(d);  chk("R2", "index 0 seconds", d, 8'h00);
        reg_read(7'h0A, d); chk("R2", "reg A", d, 8'h70);
        reg_read(7'h0B, d); chk("R2", "reg B", d, 8'h00);
        reg_read(7'h0C, d); chk("R2", "reg C", d, 8'h00);
        reg_read(7'h32, d); chk("R2", "century", d, 8'h00);
    endtask

    task automatic t_index_latch;
        logic [7:0] d;
        reg_write(7'h07, 8'h15);
        bus_read(d); chk("R1", "day first read", d, 8'h15);
        bus_read(d); chk("R1", "day second read", d, 8'h15);
        bus_write(1'b0, 8'h02);
        bus_write(1'b1, 8'h21);
        bus_write(1'b1, 8'h34);
        bus_read(d); chk("R1", "minutes after two writes", d, 8'h34);
        reg_read(7'h07, d); chk("R4", "day unaffected", d, 8'h15);
    endtask

    task automatic t_unlisted_and_d;
        logic [7:0] d;
        reg_write(7'h01, 8'hAA);
        bus_read(d); chk("R13", "offset 01", d, 8'h00);
        reg_write(7'h0E, 8'h55);
        bus_read(d); chk("R13", "offset 0E", d, 8'h00);
        reg_read(7'h00, d); chk("R13", "seconds untouched", d, 8'h00);
        reg_write(7'h0D, 8'h00);
        bus_read(d); chk("R10", "reg D after write", d, 8'h80);
    endtask

    task automatic t_controls;
        logic [7:0] d;
        reg_write(7'h0B, 8'h07);
        chk("R11", "format outputs", {5'd0, fmt_binary, fmt_24h, dst_enable}, 8'h07);
        bus_read(d); chk("R11", "reg B readback", d, 8'h07);
        reg_write(7'h0B, 8'h02);
        chk("R11", "format outputs 24h only", {5'd0, fmt_binary, fmt_24h, dst_enable}, 8'h02);
        reg_write(7'h0A, 8'hF0);
        bus_read(d); chk("R11", "reg A bit7 reads 0", d, 8'h70);
    endtask

    task automatic t_divider_held;
        logic [7:0] d;
        int unsigned base;
        reg_write(7'h0A, 8'h60);
        base = stb_count;
        wait_edge(cyc + HALF + 100);
        chk("R3", "no strobes while held", 8'(stb_count - base), 8'h00);
        reg_read(7'h0C, d); chk("R3", "no flags while held", d, 8'h00);
        reg_write(7'h0A, 8'h70);
    endtask

    task automatic t_first_and_second;
        logic [7:0] d;
        int unsigned k;
        reg_write(7'h0B, 8'h86);
        reg_write(7'h00, 8'h00);
        reg_write(7'h04, 8'h00);
        next_time = {8'h19, 8'h70, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01};
        reg_write(7'h0B, 8'h06);
        reg_read(7'h0C, d); chk("R8", "flags clear before run", d, 8'h00);
        reg_write(7'h0A, 8'h20);
        k = cyc;
        wait_edge(k + HALF - 1);
        chk("R5", "no strobe one cycle early", {7'd0, update_stb}, 8'h00);
        wait_edge(k + HALF);
        chk("R5", "strobe at half period", {7'd0, update_stb}, 8'h01);
        wait_edge(k + HALF + 1);
        chk("R6", "strobe one cycle only", {7'd0, update_stb}, 8'h00);
        reg_read(7'h00, d); chk("R5", "seconds after first update", d, 8'h01);
        reg_read(7'h32, d); chk("R4", "century loaded", d, 8'h19);
        reg_read(7'h09, d); chk("R4", "year loaded", d, 8'h70);
        reg_read(7'h0C, d); chk("R8", "update flag", d, 8'h10);
        bus_read(d); chk("R8", "flags cleared by read", d, 8'h00);
        next_time[7:0] = 8'h02;
        wait_edge(k + HALF + FULL - 1);
        chk("R6", "no strobe before full period", {7'd0, update_stb}, 8'h00);
        wait_edge(k + HALF + FULL);
        chk("R6", "strobe at full period", {7'd0, update_stb}, 8'h01);
        reg_read(7'h00, d); chk("R6", "seconds after second update", d, 8'h02);
        reg_read(7'h0C, d); chk("R6", "update flag again", d, 8'h10);
    endtask

    task automatic t_halt;
        logic [7:0] d;
        int unsigned k, base;
        reg_write(7'h0A, 8'h70);
        reg_write(7'h0B, 8'h80);
        reg_write(7'h04, 8'h11);
        reg_write(7'h02, 8'h59);
        reg_write(7'h00, 8'h59);
        next_time = {8'h20, 8'h00, 8'h00, 8'h00, 8'h12, 8'h00, 8'h00};
        base = stb_count;
        reg_write(7'h0A, 8'h20);
        k = cyc;
        wait_edge(k + HALF + 5);
        chk("R7", "no strobe while halted", 8'(stb_count - base), 8'h00);
        reg_read(7'h04, d); chk("R7", "hours kept", d, 8'h11);
        reg_read(7'h02, d); chk("R7", "minutes kept", d, 8'h59);
        reg_read(7'h00, d); chk("R7", "seconds kept", d, 8'h59);
        reg_read(7'h0C, d); chk("R7", "no flag while halted", d, 8'h00);
    endtask

    task automatic t_same_cycle;
        logic [7:0] d;
        int unsigned k;
        reg_write(7'h0A, 8'h70);
        reg_write(7'h0B, 8'h10);
        bus_write(1'b0, 8'h0C);
        reg_write(7'h0A, 8'h20);
        k = cyc;
        bus_write(1'b0, 8'h0C);
        wait_edge(k + 10);
        tick_en = 1'b0;
        wait_edge(k + 10 + GAP);
        tick_en = 1'b1;
        wait_edge(k + HALF + GAP - 1);
        chk("R12", "update delayed by missing ticks", {7'd0, update_stb}, 8'h00);
        bus_read(d);
        chk("R9", "read in set cycle sees old flags", d, 8'h00);
        bus_read(d);
        chk("R9", "flag kept after same-cycle read", d, 8'h90);
        chk("R8", "any-interrupt with enable", {7'd0, d[7]}, 8'h01);
        bus_read(d);
        chk("R8", "cleared afterwards", d, 8'h00);
        reg_read(7'h04, d); chk("R12", "hours loaded after delay", d, 8'h12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_index_latch();
        t_unlisted_and_d();
        t_controls();
        t_divider_held();
        t_first_and_second();
        t_halt();
        t_same_cycle();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (160000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule